// File: doc/BRIEF.md
# Wake-on-LAN Power Management Controller

This block decides when a network controller that has been put to sleep should wake its host. Software programs a power-management register with an enable bit and a two-bit device power state. Any state other than full power arms wake detection. While armed, the block watches three sources: a magic-packet detector, a wake-frame detector and the link-up indication from the transceiver.

A qualifying event raises two sticky status bits, one in the power-management register and one in a separate wake status register. While either bit is set, the block pulls an active-low interrupt low and drives an active-high wake pin. Software clears each status bit by writing 1 to it. A configuration register holds a global wake-on-LAN kill bit and separate disables for the magic-packet and link-change sources.

Software reaches the three registers over a small write bus with a combinational read port. The detector inputs are asynchronous. They pass through a two-flop synchroniser, and then the block detects edges on them.

Top module: `wake_pm_ctrl`

## Requirements
- R1: After reset, every register reads 0, irq_n is 1 and wake_out is 0.
- R2: Address 0 holds the power control register: bits 1:0 are the power state (0 = full power, 1..3 = sleep states), bit 8 is the enable and bit 15 is the PME status. Address 1 holds the wake status register, with the wake-interrupt bit at bit 28. Address 2 holds the configuration register: bit 0 disables magic-packet wake, bit 1 disables link-change wake and bit 2 disables all wake. Writable fields read back as written.
- R3: A rising edge on magic_pulse or wframe_pulse, or any edge on link_up, that becomes stable before clock edge k takes effect on the status at edge k+2 and not earlier.
- R4: A qualifying event sets PME status and the wake-interrupt bit, drives irq_n low and drives wake_out high.
- R5: Events are ignored, and set no status, when the power state is 0, when the enable is 0, or when the global disable is 1.
- R6: The magic-packet disable blocks only magic-packet events, and the link disable blocks only link-change events. Wake frames are gated only by the conditions of R5.
- R7: Writing 1 to bit 15 at address 0 or to bit 28 at address 1 clears that status bit alone. irq_n and wake_out are released only when both status bits are clear.
- R8: Writing 0 to a status bit has no effect. A write that returns the power state to 0 leaves PME status set.
- R9: When a qualifying event and a clearing write fall on the same clock edge, the status bit stays set.
- R10: A detector input held high for many cycles counts as one event. After it has been cleared, the status stays clear until a new rising edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| magic_pulse | input | 1 | Magic-packet detector output, asynchronous |
| wframe_pulse | input | 1 | Wake-frame detector output, asynchronous |
| link_up | input | 1 | Link status level, asynchronous |
| irq_n | output | 1 | Interrupt, active low |
| wake_out | output | 1 | Wake request pin, active high |

## Verification
A detector input changed on a falling edge is sampled at the next rising edge, k. It is synchronised by edge k+1 and recorded at edge k+2. Each check on an event therefore waits exactly three rising edges and samples on the following falling edge, and the latency test also looks one edge early to confirm that nothing is visible yet. A register write takes effect at the single rising edge after it is driven, and reads are sampled on falling edges. The collision test places the clearing write on edge k+2, the edge on which the event is recorded.

// File: rtl/wake_pm_pkg.sv
package wake_pm_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2;
  localparam int N_SRC    = 3;

  localparam int PWR_ST_LSB  = 0;
  localparam int PWR_ST_W    = 2;
  localparam int PWR_EN_BIT  = 8;
  localparam int PME_BIT     = 15;
  localparam int WINT_BIT    = 28;
  localparam int CFG_MAG_DIS = 0;
  localparam int CFG_LNK_DIS = 1;
  localparam int CFG_ALL_DIS = 2;

  localparam int SRC_MAGIC  = 0;
  localparam int SRC_WFRAME = 1;
  localparam int SRC_LINK   = 2;

  typedef enum logic [PWR_ST_W-1:0] {
    PS_FULL  = 2'd0,
    PS_SLP1  = 2'd1,
    PS_SLP2  = 2'd2,
    PS_SLP3  = 2'd3
  } pwr_state_e;

  typedef enum logic [ADDR_W-1:0] {
    RA_PWR  = 2'd0,
    RA_STAT = 2'd1,
    RA_CFG  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic pwr_en;
    pwr_state_e pwr_st;
    logic mag_dis;
    logic lnk_dis;
    logic all_dis;
  } wake_cfg_t;
endpackage

// File: rtl/wake_pm_sync.sv
module wake_pm_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = async_in;
    end else begin : g_next
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '0;
      else        stg_q[g] <= stg_d;
    end
  end

  assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/wake_pm_evt.sv
module wake_pm_evt
  import wake_pm_pkg::*;
#(
  parameter int NSRC = N_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_sync,
  input  logic            armed,
  input  logic            mag_dis,
  input  logic            lnk_dis,
  output logic [NSRC-1:0] src_hit,
  output logic            evt_any
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] prev_d;
  logic [NSRC-1:0] edge_seen;
  logic [NSRC-1:0] src_allow;

  assign prev_d = src_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if (s == SRC_LINK) begin : g_lvl
      assign edge_seen[s] = src_sync[s] ^ prev_q[s];
      assign src_allow[s] = ~lnk_dis;
    end else if (s == SRC_MAGIC) begin : g_mag
      assign edge_seen[s] = src_sync[s] & ~prev_q[s];
      assign src_allow[s] = ~mag_dis;
    end else begin : g_plain
      assign edge_seen[s] = src_sync[s] & ~prev_q[s];
      assign src_allow[s] = 1'b1;
    end
    assign src_hit[s] = armed & src_allow[s] & edge_seen[s];
  end

  assign evt_any = |src_hit;
endmodule

// File: rtl/wake_pm_regs.sv
module wake_pm_regs
  import wake_pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              evt_any,
  output wake_cfg_t         cfg,
  output logic              pme_stat,
  output logic              wint,
  output logic [REG_W-1:0]  rdata
);
  wake_cfg_t cfg_q, cfg_d;
  logic      pme_q, pme_d;
  logic      wint_q, wint_d;
  logic      wr_pwr, wr_stat, wr_cfg;

  assign wr_pwr  = bus_we && (bus_addr == RA_PWR);
  assign wr_stat = bus_we && (bus_addr == RA_STAT);
  assign wr_cfg  = bus_we && (bus_addr == RA_CFG);

  always_comb begin
    cfg_d  = cfg_q;
    pme_d  = pme_q;
    wint_d = wint_q;
    if (wr_pwr) begin
      cfg_d.pwr_en = bus_wdata[PWR_EN_BIT];
      cfg_d.pwr_st = pwr_state_e'(bus_wdata[PWR_ST_LSB +: PWR_ST_W]);
      if (bus_wdata[PME_BIT]) pme_d = 1'b0;
    end
    if (wr_stat && bus_wdata[WINT_BIT]) wint_d = 1'b0;
    if (wr_cfg) begin
      cfg_d.mag_dis = bus_wdata[CFG_MAG_DIS];
      cfg_d.lnk_dis = bus_wdata[CFG_LNK_DIS];
      cfg_d.all_dis = bus_wdata[CFG_ALL_DIS];
    end
    if (evt_any) begin
      pme_d  = 1'b1;
      wint_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pme_q  <= 1'b0;
      wint_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      pme_q  <= pme_d;
      wint_q <= wint_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (bus_addr)
      RA_PWR: begin
        rdata[PWR_ST_LSB +: PWR_ST_W] = cfg_q.pwr_st;
        rdata[PWR_EN_BIT]             = cfg_q.pwr_en;
        rdata[PME_BIT]                = pme_q;
      end
      RA_STAT: rdata[WINT_BIT] = wint_q;
      RA_CFG: begin
        rdata[CFG_MAG_DIS] = cfg_q.mag_dis;
        rdata[CFG_LNK_DIS] = cfg_q.lnk_dis;
        rdata[CFG_ALL_DIS] = cfg_q.all_dis;
      end
      default: rdata = '0;
    endcase
  end

  assign cfg      = cfg_q;
  assign pme_stat = pme_q;
  assign wint     = wint_q;
endmodule

// File: rtl/wake_pm_ctrl.sv
module wake_pm_ctrl
  import wake_pm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              magic_pulse,
  input  logic              wframe_pulse,
  input  logic              link_up,
  output logic              irq_n,
  output logic              wake_out
);
  logic [N_SRC-1:0] src_raw;
  logic [N_SRC-1:0] src_sync;
  logic [N_SRC-1:0] src_hit;
  logic             evt_any;
  logic             armed;
  logic             pme_stat;
  logic             wint;
  wake_cfg_t        cfg;

  assign src_raw[SRC_MAGIC]  = magic_pulse;
  assign src_raw[SRC_WFRAME] = wframe_pulse;
  assign src_raw[SRC_LINK]   = link_up;

  wake_pm_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (src_raw),
    .sync_out (src_sync)
  );

  assign armed = cfg.pwr_en && (cfg.pwr_st != PS_FULL) && !cfg.all_dis;

  wake_pm_evt #(.NSRC(N_SRC)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sync (src_sync),
    .armed    (armed),
    .mag_dis  (cfg.mag_dis),
    .lnk_dis  (cfg.lnk_dis),
    .src_hit  (src_hit),
    .evt_any  (evt_any)
  );

  wake_pm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_any   (evt_any),
    .cfg       (cfg),
    .pme_stat  (pme_stat),
    .wint      (wint),
    .rdata     (bus_rdata)
  );

  assign wake_out = pme_stat | wint;
  assign irq_n    = ~(pme_stat | wint);
endmodule

// File: rtl/wake_pm_ctrl_chk.sv
module wake_pm_ctrl_chk
  import wake_pm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic              evt_any,
  input logic              armed,
  input logic              pme_stat,
  input logic              wint
);
  logic clr_pme, clr_wint;
  assign clr_pme  = bus_we && (bus_addr == RA_PWR)  && bus_wdata[PME_BIT];
  assign clr_wint = bus_we && (bus_addr == RA_STAT) && bus_wdata[WINT_BIT];

  p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any |=> (pme_stat && wint));

  p_disarmed_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !pme_stat && !wint) |=> (!pme_stat && !wint));

  p_pme_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pme && !evt_any) |=> !pme_stat);

  p_wint_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wint && !evt_any) |=> !wint);

  p_pme_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_stat && !clr_pme) |=> pme_stat);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_any && clr_pme) |=> pme_stat);
endmodule

bind wake_pm_ctrl wake_pm_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .evt_any   (evt_any),
  .armed     (armed),
  .pme_stat  (pme_stat),
  .wint      (wint)
);

// File: tb/wake_pm_ctrl_test.sv
module wake_pm_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        magic_pulse, wframe_pulse, link_up;
  logic        irq_n, wake_out;

  int n_tests;
  int n_fail;
  bit done;

  wake_pm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .magic_pulse(magic_pulse), .wframe_pulse(wframe_pulse), .link_up(link_up),
    .irq_n(irq_n), .wake_out(wake_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Drives a source change on a falling edge, returns on the falling edge after edge k.
  task automatic fire(input int src);
    @(negedge clk);
    if (src == 0) magic_pulse = 1'b1;
    else if (src == 1) wframe_pulse = 1'b1;
    else link_up = ~link_up;
    @(posedge clk);
    @(negedge clk);
    magic_pulse = 1'b0; wframe_pulse = 1'b0;
  endtask

  task automatic settle;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  // Returns {pme, wint, irq asserted, wake}
  task automatic observe(output logic [3:0] v);
    logic [31:0] p, s;
    rd(2'd0, p);
    rd(2'd1, s);
    v = {p[15], s[28], ~irq_n, wake_out};
  endtask

  task automatic clear_all(input logic [31:0] pwr_val);
    wr(2'd0, pwr_val | 32'h8000);
    wr(2'd1, 32'h1000_0000);
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired got=%h expected=%h", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [3:0]  v;
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    magic_pulse = 1'b0; wframe_pulse = 1'b0; link_up = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check(d == 0, "R1 register after reset", d, 0);
    end
    check(irq_n === 1'b1 && wake_out === 1'b0, "R1 outputs after reset",
          {30'd0, irq_n, wake_out}, 32'h2);

    // R2 readback
    wr(2'd2, 32'h0000_0007);
    rd(2'd2, d);
    check(d == 32'h7, "R2 config readback", d, 32'h7);
    wr(2'd0, 32'h0000_0103);
    rd(2'd0, d);
    check(d == 32'h103, "R2 power register readback", d, 32'h103);

    // R4 R5 R6 sweep over state, enable, disables and source
    for (int st = 0; st < 4; st++)
      for (int en = 0; en < 2; en++)
        for (int cf = 0; cf < 8; cf++)
          for (int src = 0; src < 3; src++) begin
            logic [31:0] pv;
            bit arm, hit;
            pv = (en << 8) | st;
            wr(2'd2, cf);
            clear_all(pv);
            fire(src);
            settle();
            observe(v);
            arm = (en == 1) && (st != 0) && (cf[2] == 1'b0);
            hit = arm && ((src == 0) ? !cf[0] : (src == 2) ? !cf[1] : 1'b1);
            check(v == {4{hit}},
                  (src == 1) ? "R5 wake-frame gating" : "R6 per-source gating",
                  {28'd0, v}, {28'd0, {4{hit}}});
            clear_all(pv);
          end

    // R3 latency: not visible at edge k+1, visible at edge k+2
    wr(2'd2, 32'h0);
    clear_all(32'h0000_0102);
    fire(1);
    @(posedge clk); @(negedge clk);
    observe(v);
    check(v == 4'b0000, "R3 status too early", {28'd0, v}, 32'h0);
    @(posedge clk); @(negedge clk);
    observe(v);
    check(v == 4'b1111, "R3 status at latency", {28'd0, v}, 32'hF);

    // R7 independent clears, outputs held until both clear
    wr(2'd0, 32'h0000_8102);
    observe(v);
    check(v == 4'b0111, "R7 clear PME only", {28'd0, v}, 32'h7);
    wr(2'd1, 32'h1000_0000);
    observe(v);
    check(v == 4'b0000, "R7 both cleared releases pins", {28'd0, v}, 32'h0);

    // R8 return to full power and zero writes leave status set
    fire(2);
    settle();
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, 32'h0);
    observe(v);
    check(v == 4'b1111, "R8 status kept", {28'd0, v}, 32'hF);
    rd(2'd0, d);
    check(d == 32'h8100, "R8 power state 0 with PME set", d, 32'h8100);
    clear_all(32'h0000_0103);

    // R9 event and clear on the same edge
    fire(0);
    settle();
    fire(0);
    @(posedge clk);
    wr(2'd0, 32'h0000_8103);
    observe(v);
    check(v[3] == 1'b1, "R9 set wins over clear", {31'd0, v[3]}, 32'h1);
    clear_all(32'h0000_0103);
    observe(v);
    check(v == 4'b0000, "R9 cleared afterwards", {28'd0, v}, 32'h0);

    // R10 held input counts once
    @(negedge clk);
    magic_pulse = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    observe(v);
    check(v == 4'b1111, "R10 held input sets once", {28'd0, v}, 32'hF);
    clear_all(32'h0000_0103);
    repeat (5) @(posedge clk);
    @(negedge clk);
    observe(v);
    check(v == 4'b0000, "R10 held input does not re-set", {28'd0, v}, 32'h0);
    magic_pulse = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    observe(v);
    check(v == 4'b0000, "R10 falling edge ignored", {28'd0, v}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule